// File: doc/BRIEF.md
# Time-shared three-channel volume mixer

This block turns three 4-bit amplitude codes into three 8-bit unsigned output levels and a 10-bit unsigned total. There is only one volume lookup table, and the three channels take turns using it. Each clock-enable pulse moves a channel pointer one step through the fixed order A, B, C and back to A. At each pulse the table address is latched from the selected channel's code. The table result is ready after one system clock. It is written into that channel's output register at the following enable pulse.

The block has no wait states. Instead it depends on the caller's clock enable: between any two enable-high cycles there must be at least one cycle with enable low, and the table read happens in that idle cycle. The amplitude inputs are plain level pins with no handshake. The block samples them only at enable pulses and never stalls them, so back-pressure does not arise. The three channel outputs are plain registered levels, valid at all times. The total is registered one clock after the channel registers.

The table follows a model of an output stage with 16 switched devices per channel. At level L one device conducts with resistance 900·1.55^(15−L) Ω. The other fifteen devices are each 3 MΩ. These sixteen resistances combine in parallel into one impedance Z, which forms a divider against a 1 kΩ load. The divider ratio d(L) = 1000/(1000+Z) is scaled so that level 15 gives 255.

Top module: `shared_vol_mixer`

## Requirements
- R1: While rst_n is low (asynchronous, active low), out_a, out_b, out_c and out_sum are all zero.
- R2: A channel code L is converted to round(255·d(L)/d(15)), with d(L) as defined above; rounding is to the nearest integer.
- R3: The table gives 255 for code 15, and its values never decrease as the code rises.
- R4: Channels are serviced in the order A, B, C, A, ... starting at A after reset. At most one channel output changes per enable pulse.
- R5: The code read from the selected channel at an enable pulse appears on that channel's output in the cycle after the next enable pulse. The first enable pulse after reset changes no output.
- R6: out_sum equals the zero-extended sum out_a+out_b+out_c as it stood one clock earlier.
- R7: cen is never high in two consecutive cycles; this is a usage rule that the block checks.
- R8: The channel outputs change only in the cycle that follows an enable-high cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous reset, active low |
| cen | input | 1 | clock enable, at least one low cycle between highs |
| lvl_a | input | 4 | amplitude code, channel A |
| lvl_b | input | 4 | amplitude code, channel B |
| lvl_c | input | 4 | amplitude code, channel C |
| out_a | output | 8 | converted level, channel A |
| out_b | output | 8 | converted level, channel B |
| out_c | output | 8 | converted level, channel C |
| out_sum | output | 10 | sum of the three channel levels |

## Verification
The assertions check the following on every cycle:
- the enable spacing rule;
- that at most one channel output moves per pulse, and only right after a pulse;
- that the total follows the registered channel values one clock later;
- that code 15 reads back as full scale.

Other behaviour can only be shown by the bench's scenarios. These include the exact table values for every code on every channel, the A-B-C rotation and the one-pulse write delay. The bench sweeps all sixteen codes across all channels, with enable gaps of different lengths.

// File: rtl/vmix_pkg.sv
package vmix_pkg;
  localparam int LVL_W  = 4;
  localparam int OUT_W  = 8;
  localparam int NCH    = 3;
  localparam int NLVL   = 1 << LVL_W;
  localparam int SUM_W  = OUT_W + $clog2(NCH + 1);
  localparam int PTR_W  = $clog2(NCH);

  typedef logic [PTR_W-1:0] chan_t;
  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [OUT_W-1:0] level_t;

  // divider ratio for a given code: one device on, the rest off, against the load
  function automatic real divider_ratio(input int code);
    real r_on, g_tot, z;
    r_on = 900.0;
    for (int k = code; k < NLVL - 1; k++) r_on = r_on * 1.55;
    g_tot = (1.0 / r_on) + real'(NLVL - 1) / 3.0e6;
    z = 1.0 / g_tot;
    return 1000.0 / (1000.0 + z);
  endfunction

  // whole table packed, entry i at bits [i*OUT_W +: OUT_W]
  function automatic logic [NLVL*OUT_W-1:0] build_table();
    logic [NLVL*OUT_W-1:0] t;
    real full, v;
    t = '0;
    full = divider_ratio(NLVL - 1);
    for (int i = 0; i < NLVL; i++) begin
      v = real'((1 << OUT_W) - 1) * divider_ratio(i) / full;
      t[i*OUT_W +: OUT_W] = OUT_W'($rtoi(v + 0.5));
    end
    return t;
  endfunction
endpackage

// File: rtl/vmix_rom.sv
module vmix_rom
  import vmix_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  lvl_t   addr,
  output level_t q
);
  localparam logic [NLVL*OUT_W-1:0] TABLE = build_table();

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= TABLE[addr*OUT_W +: OUT_W];
  end

  // full-scale code reads as full scale one clock later
  assert_full_scale_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == lvl_t'(NLVL - 1)) |=> (q == level_t'((1 << OUT_W) - 1)));
endmodule

// File: rtl/vmix_seq.sv
module vmix_seq
  import vmix_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cen,
  output chan_t cur_ch,
  output chan_t wr_ch,
  output logic  wr_ok
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_ch <= '0;
      wr_ch  <= '0;
      wr_ok  <= 1'b0;
    end else if (cen) begin
      wr_ch  <= cur_ch;
      wr_ok  <= 1'b1;
      cur_ch <= (cur_ch == chan_t'(NCH - 1)) ? '0 : chan_t'(cur_ch + 1'b1);
    end
  end

  // pointer always moves one step in rotation on a pulse
  assert_rotate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cen |=> (cur_ch == (($past(cur_ch) == chan_t'(NCH - 1)) ? chan_t'(0)
                                                            : chan_t'($past(cur_ch) + 1'b1))));
endmodule

// File: rtl/shared_vol_mixer.sv
module shared_vol_mixer
  import vmix_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cen,
  input  logic [3:0]            lvl_a,
  input  logic [3:0]            lvl_b,
  input  logic [3:0]            lvl_c,
  output logic [7:0]            out_a,
  output logic [7:0]            out_b,
  output logic [7:0]            out_c,
  output logic [9:0]            out_sum
);
  lvl_t   lvl_in [NCH];
  level_t ch_q   [NCH];
  chan_t  cur_ch, wr_ch;
  logic   wr_ok;
  lvl_t   rom_addr;
  level_t rom_q;

  assign lvl_in[0] = lvl_a;
  assign lvl_in[1] = lvl_b;
  assign lvl_in[2] = lvl_c;

  vmix_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cen(cen),
    .cur_ch(cur_ch), .wr_ch(wr_ch), .wr_ok(wr_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rom_addr <= '0;
    else if (cen) rom_addr <= lvl_in[cur_ch];
  end

  vmix_rom u_rom (.clk(clk), .rst_n(rst_n), .addr(rom_addr), .q(rom_q));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 ch_q[g] <= '0;
      else if (cen && wr_ok && wr_ch == chan_t'(g)) ch_q[g] <= rom_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_sum <= '0;
    else        out_sum <= SUM_W'(ch_q[0]) + SUM_W'(ch_q[1]) + SUM_W'(ch_q[2]);
  end

  assign out_a = ch_q[0];
  assign out_b = ch_q[1];
  assign out_c = ch_q[2];

  assert_cen_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cen |=> !cen);

  assert_one_chan_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!$stable(out_a), !$stable(out_b), !$stable(out_c)}) <= 1);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cen) |-> ($stable(out_a) && $stable(out_b) && $stable(out_c)));

  assert_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_sum == $past(10'(out_a) + 10'(out_b) + 10'(out_c))));
endmodule

// File: tb/shared_vol_mixer_tb.sv
module shared_vol_mixer_tb;
  logic clk = 0, rst_n = 0, cen = 0;
  logic [3:0] la = 0, lb = 0, lc = 0;
  logic [7:0] oa, ob, oc;
  logic [9:0] osum;
  int checks = 0, fails = 0;
  int ref_tab [16];

  always #5 clk = ~clk;

  shared_vol_mixer u_dut (
    .clk(clk), .rst_n(rst_n), .cen(cen),
    .lvl_a(la), .lvl_b(lb), .lvl_c(lc),
    .out_a(oa), .out_b(ob), .out_c(oc), .out_sum(osum)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one enable pulse followed by gap idle cycles; inputs change at negedge
  task automatic pulse(input int gap);
    @(negedge clk) cen = 1;
    @(negedge clk) cen = 0;
    repeat (gap - 1) @(negedge clk);
  endtask

  function automatic real ratio(input int lvl);
    real ron, z;
    ron = 900.0 * (1.55 ** real'(15 - lvl));
    z = 1.0 / (1.0 / ron + 1.0 / 200000.0);
    return 1000.0 / (1000.0 + z);
  endfunction

  initial begin
    #1500000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) ref_tab[i] = $rtoi(255.0 * ratio(i) / ratio(15) + 0.5);
    la = 4'd15; lb = 4'd15; lc = 4'd15;
    repeat (3) @(negedge clk);
    chk("R1 a", oa, 0); chk("R1 b", ob, 0); chk("R1 c", oc, 0); chk("R1 sum", osum, 0);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    // R3 table shape from reference
    chk("R3 full", ref_tab[15], 255);
    // R5: first pulse writes nothing
    pulse(2);
    chk("R5 first a", oa, 0); chk("R5 first b", ob, 0); chk("R5 first c", oc, 0);
    // R4: second pulse writes A only
    la = 4'd3; lb = 4'd9;
    pulse(2);
    chk("R4 a first", oa, 255); chk("R4 b untouched", ob, 0); chk("R4 c untouched", oc, 0);
    // third pulse writes B with code sampled at pulse two (9)
    pulse(3);
    chk("R4 b second", ob, ref_tab[9]); chk("R4 c still", oc, 0); chk("R4 a kept", oa, 255);
    // fourth writes C with 15 (sampled at pulse three)
    pulse(2);
    chk("R4 c third", oc, 255);
    chk("R6 sum", osum, 255 + ref_tab[9] + 255);
    // R8: no change while cen stays low
    lc = 4'd0; la = 4'd0; lb = 4'd0;
    repeat (5) @(negedge clk);
    chk("R8 hold a", oa, 255); chk("R8 hold c", oc, 255);
    // R2 exhaustive sweep across all channels, varying gaps
    for (int l = 0; l < 16; l++) begin
      la = 4'(l); lb = 4'(15 - l); lc = 4'((l + 5) % 16);
      for (int p = 0; p < 4; p++) pulse(2 + (l % 3));
      @(negedge clk);
      chk("R2 a", oa, ref_tab[l]);
      chk("R2 b", ob, ref_tab[15 - l]);
      chk("R2 c", oc, ref_tab[(l + 5) % 16]);
      chk("R6 sweep sum", osum, ref_tab[l] + ref_tab[15 - l] + ref_tab[(l + 5) % 16]);
    end
    // R3 monotone reference vs outputs at code 15 and 0
    for (int i = 1; i < 16; i++) chk("R3 mono", int'(ref_tab[i] >= ref_tab[i-1]), 1);
    // R1 asynchronous reset mid-run
    #2 rst_n = 0; #1;
    chk("R1 async a", oa, 0); chk("R1 async sum", osum, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule